// File: doc/BRIEF.md
# SCSI DMA Channel Register Engine

This block is the control and status register set of a bus-master DMA channel that sits next to a SCSI protocol core. Software programs a start count, a start address and a start descriptor address. It then writes a command word. A START command copies the three start values into working copies. The working count and working address then track progress as the memory side asks to move data. Each transfer request carries a length and a direction. The block rejects a request whose direction disagrees with the programmed one. It clips an accepted request to the bytes still owed, then advances the working pair. When the SCSI core reports that the command has finished, the working count drops to zero and a done flag is raised.

Status flags can be acknowledged in two ways, chosen by one bit of a separate bus-control register. With the bit low, software writes ones to clear flags. With the bit high, status writes are ignored and a status read clears the flags after returning them. The SCSI core's interrupt line is merged into the status value on every read. An interrupt output combines the done flag and the SCSI interrupt, each gated by its own enable in the command word. Register reads return data one cycle after the request. Transfer requests are answered one cycle after they are presented.

Top module: `dma_chan_csr`

## Requirements
- R1: After reset, reads return: command 0, working count 0, working address 0xFFFFFFFF, working descriptor address 0xFFFFFFFD, status 0. The outputs dmaEnable, irq and abortReq are low.
- R2: Word indices 1, 2 and 6 hold the start count, start address and start descriptor address, and read back what was written. Writes to indices 3, 4 and 7 (the working count, address and descriptor address) change nothing. Writes to indices above 8 change nothing. Reads of indices above 8 return 0.
- R3: A write to index 0 with bits [1:0] = 3 (START) does three things. It loads working count, address and descriptor address from their start registers. It clears status bits 0 to 5. It raises dmaEnable.
- R4: Command bits [1:0] = 0 (IDLE) drop dmaEnable. A value of 1 (BLAST) leaves dmaEnable and the counters unchanged. A value of 2 (ABORT) raises abortReq for exactly one cycle, in the cycle after the write.
- R5: A transfer request is rejected when xferToMem differs from command bit 7 (1 = device to memory). A rejected request gets xferAccepted = 0 and xferGrantLen = 0, and the counters do not change.
- R6: An accepted request is granted min(xferLen, working count) bytes. The working count is reduced by the grant and the working address is increased by it.
- R7: A cmdDone pulse sets working count to 0 and sets status bit 3 (done).
- R8: With bus-control (index 8) bit 12 = 0, writing ones to status bits 1, 2 or 3 clears those bits.
- R9: With bus-control bit 12 = 1, status writes are ignored. A status read returns the current value and then clears bits 1 to 3.
- R10: A status read shows bit 4 = 1 whenever scsiIntIn is high.
- R11: irq is high when status bit 3 is set and command bit 6 is 1, or when scsiIntIn is high and command bit 5 is 1.
- R12: When events coincide, setting done beats clearing it, and the cmdDone zeroing of working count beats any transfer decrement or START load. A transfer still advances the working address in that cycle.
- R13: regRdValid pulses one cycle after regRdEn, carrying the value sampled at that edge. xferRespValid pulses one cycle after xferReq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | ADDR_W | Word index |
| regWrData | input | DATA_W | Write data |
| regRdData | output | DATA_W | Read data, valid with regRdValid |
| regRdValid | output | 1 | Read data valid |
| scsiIntIn | input | 1 | Interrupt flag from the SCSI core |
| xferReq | input | 1 | Transfer request |
| xferToMem | input | 1 | Request direction, 1 = device to memory |
| xferLen | input | DATA_W | Requested byte count |
| xferRespValid | output | 1 | Response to a transfer request |
| xferAccepted | output | 1 | Request direction matched |
| xferGrantLen | output | DATA_W | Bytes granted |
| cmdDone | input | 1 | SCSI command completion pulse |
| dmaEnable | output | 1 | DMA enabled |
| abortReq | output | 1 | Cancel the active request |
| irq | output | 1 | Interrupt request |

## Verification
The done flag has three sources of change: cmdDone sets it, a write-one clears it, and, in the other policy, a status read clears it. cmdDone can arrive in the same cycle as the write that clears it. The bench raises cmdDone during a write of ones to the status word and expects done to survive in the next status read. It also raises cmdDone together with an accepted transfer right after a START. There it expects the grant to follow the reloaded count, the working count to end at zero and the working address to have advanced by the grant.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  localparam int NUM_DMA_REGS = 8;

  // word indices of the register window
  localparam int IDX_CMD    = 0;
  localparam int IDX_SCNT   = 1;
  localparam int IDX_SADR   = 2;
  localparam int IDX_WCNT   = 3;
  localparam int IDX_WADR   = 4;
  localparam int IDX_STAT   = 5;
  localparam int IDX_SDESC  = 6;
  localparam int IDX_WDESC  = 7;
  localparam int IDX_BUSCTL = 8;

  // command word fields
  localparam int CMD_IE_SINT = 5;
  localparam int CMD_IE_DONE = 6;
  localparam int CMD_DIR     = 7;

  // status bits
  localparam int STAT_W   = 6;
  localparam int ST_PWDN  = 0;
  localparam int ST_ERR   = 1;
  localparam int ST_ABT   = 2;
  localparam int ST_DONE  = 3;
  localparam int ST_SINT  = 4;
  localparam int ST_BLK   = 5;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_BLAST = 2'd1,
    OP_ABORT = 2'd2,
    OP_START = 2'd3
  } dmaOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic ldCmd;
    logic ldStartCnt;
    logic ldStartAdr;
    logic ldStartDesc;
    logic ldBusCtl;
    logic wrStat;
    logic rdStat;
    logic rdCapture;
    logic opStart;
    logic opIdle;
    logic opAbort;
    logic xferGo;
    logic xferResp;
  } dpStrobe_t;

endpackage

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [1:0]        cmdOpIn,
  input  logic              rdClearMode,
  input  logic              cmdDirToMem,
  input  logic              xferReq,
  input  logic              xferToMem,
  output dpStrobe_t         stb
);

  localparam logic [ADDR_W-1:0] A_CMD    = ADDR_W'(IDX_CMD);
  localparam logic [ADDR_W-1:0] A_SCNT   = ADDR_W'(IDX_SCNT);
  localparam logic [ADDR_W-1:0] A_SADR   = ADDR_W'(IDX_SADR);
  localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(IDX_STAT);
  localparam logic [ADDR_W-1:0] A_SDESC  = ADDR_W'(IDX_SDESC);
  localparam logic [ADDR_W-1:0] A_BUSCTL = ADDR_W'(IDX_BUSCTL);

  dmaOp_e opCode;
  logic   dirMatch;

  assign opCode   = dmaOp_e'(cmdOpIn);
  assign dirMatch = (xferToMem == cmdDirToMem);

  always_comb begin
    stb = '0;
    if (regWrEn) begin
      case (regAddr)
        A_CMD:    stb.ldCmd       = 1'b1;
        A_SCNT:   stb.ldStartCnt  = 1'b1;
        A_SADR:   stb.ldStartAdr  = 1'b1;
        A_SDESC:  stb.ldStartDesc = 1'b1;
        A_BUSCTL: stb.ldBusCtl    = 1'b1;
        A_STAT:   stb.wrStat      = !rdClearMode;
        default:  ;
      endcase
    end
    if (stb.ldCmd) begin
      case (opCode)
        OP_IDLE:  stb.opIdle  = 1'b1;
        OP_ABORT: stb.opAbort = 1'b1;
        OP_START: stb.opStart = 1'b1;
        default:  ;
      endcase
    end
    stb.rdCapture = regRdEn;
    stb.rdStat    = regRdEn && (regAddr == A_STAT) && rdClearMode;
    stb.xferResp  = xferReq;
    stb.xferGo    = xferReq && dirMatch;
  end

endmodule

// File: rtl/dma_chan_dp.sv
module dma_chan_dp
  import dma_chan_pkg::*;
#(
  parameter int                DATA_W      = 32,
  parameter int                ADDR_W      = 4,
  parameter int                SEL_BIT     = 12,
  parameter logic [DATA_W-1:0] WADR_RESET  = '1,
  parameter logic [DATA_W-1:0] WDESC_RESET = {{(DATA_W-2){1'b1}}, 2'b01}
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              scsiIntIn,
  input  logic              cmdDone,
  input  logic [DATA_W-1:0] xferLen,
  output logic [DATA_W-1:0] regRdData,
  output logic              regRdValid,
  output logic              xferRespValid,
  output logic              xferAccepted,
  output logic [DATA_W-1:0] xferGrantLen,
  output logic              dmaEnable,
  output logic              abortReq,
  output logic              irq,
  output logic              cmdDir,
  output logic              rdClearMode,
  output logic              ieDone,
  output logic              doneBit,
  output logic [DATA_W-1:0] workCnt
);

  localparam logic [ADDR_W-1:0] A_CMD    = ADDR_W'(IDX_CMD);
  localparam logic [ADDR_W-1:0] A_SCNT   = ADDR_W'(IDX_SCNT);
  localparam logic [ADDR_W-1:0] A_SADR   = ADDR_W'(IDX_SADR);
  localparam logic [ADDR_W-1:0] A_WCNT   = ADDR_W'(IDX_WCNT);
  localparam logic [ADDR_W-1:0] A_WADR   = ADDR_W'(IDX_WADR);
  localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(IDX_STAT);
  localparam logic [ADDR_W-1:0] A_SDESC  = ADDR_W'(IDX_SDESC);
  localparam logic [ADDR_W-1:0] A_WDESC  = ADDR_W'(IDX_WDESC);
  localparam logic [ADDR_W-1:0] A_BUSCTL = ADDR_W'(IDX_BUSCTL);

  // flags that software acknowledges
  localparam logic [STAT_W-1:0] ACK_MASK =
    STAT_W'((1 << ST_ERR) | (1 << ST_ABT) | (1 << ST_DONE));

  logic [DATA_W-1:0] cmdQ, startCntQ, startAdrQ, startDescQ;
  logic [DATA_W-1:0] workCntQ, workAdrQ, workDescQ, busCtlQ;
  logic [STAT_W-1:0] statQ, statNext;
  logic [DATA_W-1:0] grantLen, statView, rdMux;
  logic              dmaEnQ, abortQ;
  logic              rdValidQ, respValidQ, respAccQ;
  logic [DATA_W-1:0] rdDataQ, respLenQ;

  assign grantLen = (xferLen < workCntQ) ? xferLen : workCntQ;
  assign statView = DATA_W'(statQ) | (DATA_W'(scsiIntIn) << ST_SINT);

  // next status: clears first, completion set last so it wins
  always_comb begin
    statNext = statQ;
    if (stb.opStart) statNext = '0;
    if (stb.wrStat)  statNext = statNext & ~(regWrData[STAT_W-1:0] & ACK_MASK);
    if (stb.rdStat)  statNext = statNext & ~ACK_MASK;
    if (cmdDone)     statNext[ST_DONE] = 1'b1;
  end

  always_comb begin
    case (regAddr)
      A_CMD:    rdMux = cmdQ;
      A_SCNT:   rdMux = startCntQ;
      A_SADR:   rdMux = startAdrQ;
      A_WCNT:   rdMux = workCntQ;
      A_WADR:   rdMux = workAdrQ;
      A_STAT:   rdMux = statView;
      A_SDESC:  rdMux = startDescQ;
      A_WDESC:  rdMux = workDescQ;
      A_BUSCTL: rdMux = busCtlQ;
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ       <= '0;
      startCntQ  <= '0;
      startAdrQ  <= '0;
      startDescQ <= '0;
      workCntQ   <= '0;
      workAdrQ   <= WADR_RESET;
      workDescQ  <= WDESC_RESET;
      busCtlQ    <= '0;
      statQ      <= '0;
      dmaEnQ     <= 1'b0;
      abortQ     <= 1'b0;
      rdValidQ   <= 1'b0;
      rdDataQ    <= '0;
      respValidQ <= 1'b0;
      respAccQ   <= 1'b0;
      respLenQ   <= '0;
    end else begin
      if (stb.ldCmd)       cmdQ       <= regWrData;
      if (stb.ldStartCnt)  startCntQ  <= regWrData;
      if (stb.ldStartAdr)  startAdrQ  <= regWrData;
      if (stb.ldStartDesc) startDescQ <= regWrData;
      if (stb.ldBusCtl)    busCtlQ    <= regWrData;

      if (cmdDone)         workCntQ <= '0;
      else if (stb.opStart) workCntQ <= startCntQ;
      else if (stb.xferGo)  workCntQ <= workCntQ - grantLen;

      if (stb.opStart)     workAdrQ <= startAdrQ;
      else if (stb.xferGo) workAdrQ <= workAdrQ + grantLen;

      if (stb.opStart)     workDescQ <= startDescQ;

      statQ <= statNext;

      if (stb.opStart)     dmaEnQ <= 1'b1;
      else if (stb.opIdle) dmaEnQ <= 1'b0;
      abortQ <= stb.opAbort;

      rdValidQ <= stb.rdCapture;
      if (stb.rdCapture) rdDataQ <= rdMux;

      respValidQ <= stb.xferResp;
      respAccQ   <= stb.xferGo;
      respLenQ   <= stb.xferGo ? grantLen : '0;
    end
  end

  assign regRdData     = rdDataQ;
  assign regRdValid    = rdValidQ;
  assign xferRespValid = respValidQ;
  assign xferAccepted  = respAccQ;
  assign xferGrantLen  = respLenQ;
  assign dmaEnable     = dmaEnQ;
  assign abortReq      = abortQ;
  assign irq           = (statQ[ST_DONE] & cmdQ[CMD_IE_DONE]) |
                         (scsiIntIn & cmdQ[CMD_IE_SINT]);
  assign cmdDir        = cmdQ[CMD_DIR];
  assign rdClearMode   = busCtlQ[SEL_BIT];
  assign ieDone        = cmdQ[CMD_IE_DONE];
  assign doneBit       = statQ[ST_DONE];
  assign workCnt       = workCntQ;

endmodule

// File: rtl/dma_chan_csr.sv
module dma_chan_csr
  import dma_chan_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 4,
  parameter int SEL_BIT = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              regRdValid,
  input  logic              scsiIntIn,
  input  logic              xferReq,
  input  logic              xferToMem,
  input  logic [DATA_W-1:0] xferLen,
  output logic              xferRespValid,
  output logic              xferAccepted,
  output logic [DATA_W-1:0] xferGrantLen,
  input  logic              cmdDone,
  output logic              dmaEnable,
  output logic              abortReq,
  output logic              irq
);

  dpStrobe_t         stb;
  logic              cmdDir;
  logic              rdClearMode;
  logic              ieDone;
  logic              doneBit;
  logic [DATA_W-1:0] workCnt;

  dma_chan_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regWrEn     (regWrEn),
    .regRdEn     (regRdEn),
    .regAddr     (regAddr),
    .cmdOpIn     (regWrData[1:0]),
    .rdClearMode (rdClearMode),
    .cmdDirToMem (cmdDir),
    .xferReq     (xferReq),
    .xferToMem   (xferToMem),
    .stb         (stb)
  );

  dma_chan_dp #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .SEL_BIT (SEL_BIT)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .stb           (stb),
    .regAddr       (regAddr),
    .regWrData     (regWrData),
    .scsiIntIn     (scsiIntIn),
    .cmdDone       (cmdDone),
    .xferLen       (xferLen),
    .regRdData     (regRdData),
    .regRdValid    (regRdValid),
    .xferRespValid (xferRespValid),
    .xferAccepted  (xferAccepted),
    .xferGrantLen  (xferGrantLen),
    .dmaEnable     (dmaEnable),
    .abortReq      (abortReq),
    .irq           (irq),
    .cmdDir        (cmdDir),
    .rdClearMode   (rdClearMode),
    .ieDone        (ieDone),
    .doneBit       (doneBit),
    .workCnt       (workCnt)
  );

endmodule

// File: rtl/dma_chan_csr_chk.sv
module dma_chan_csr_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [1:0]        cmdOp,
  input logic              regRdValid,
  input logic              xferRespValid,
  input logic              xferAccepted,
  input logic [DATA_W-1:0] xferGrantLen,
  input logic [DATA_W-1:0] workCnt,
  input logic              cmdDone,
  input logic              dmaEnable,
  input logic              abortReq,
  input logic              irq,
  input logic              doneBit,
  input logic              ieDone
);

  logic cmdWr;
  assign cmdWr = regWrEn && (regAddr == '0);

  a_r3_start_enables: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && cmdOp == 2'd3) |=> dmaEnable);

  a_r4_idle_disables: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && cmdOp == 2'd0) |=> !dmaEnable);

  a_r4_abort_follows_cmd: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |-> $past(cmdWr && cmdOp == 2'd2));

  a_r5_reject_zero_len: assert property (@(posedge clk) disable iff (!rstN)
    (xferRespValid && !xferAccepted) |-> xferGrantLen == '0);

  a_r6_grant_within_count: assert property (@(posedge clk) disable iff (!rstN)
    xferRespValid |-> xferGrantLen <= $past(workCnt));

  a_r7_done_zeroes_count: assert property (@(posedge clk) disable iff (!rstN)
    cmdDone |=> (doneBit && workCnt == '0));

  a_r11_irq_on_done: assert property (@(posedge clk) disable iff (!rstN)
    (doneBit && ieDone) |-> irq);

  a_r13_read_latency: assert property (@(posedge clk) disable iff (!rstN)
    regRdEn |=> regRdValid);

endmodule

bind dma_chan_csr dma_chan_csr_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .regWrEn       (regWrEn),
  .regRdEn       (regRdEn),
  .regAddr       (regAddr),
  .cmdOp         (regWrData[1:0]),
  .regRdValid    (regRdValid),
  .xferRespValid (xferRespValid),
  .xferAccepted  (xferAccepted),
  .xferGrantLen  (xferGrantLen),
  .workCnt       (workCnt),
  .cmdDone       (cmdDone),
  .dmaEnable     (dmaEnable),
  .abortReq      (abortReq),
  .irq           (irq),
  .doneBit       (doneBit),
  .ieDone        (ieDone)
);

// File: tb/dma_chan_csr_tb.sv
`timescale 1ns/1ps
module dma_chan_csr_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        regRdValid;
  logic        scsiIntIn = 1'b0;
  logic        xferReq = 1'b0, xferToMem = 1'b0;
  logic [31:0] xferLen = '0;
  logic        xferRespValid, xferAccepted;
  logic [31:0] xferGrantLen;
  logic        cmdDone = 1'b0;
  logic        dmaEnable, abortReq, irq;

  int nChecks = 0;
  int nFails  = 0;

  logic [31:0] rdExpQ[$];
  string       rdTagQ[$];
  logic [32:0] xfExpQ[$];
  string       xfTagQ[$];

  always #2.5 clk = ~clk;

  dma_chan_csr u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .regRdValid(regRdValid), .scsiIntIn(scsiIntIn), .xferReq(xferReq),
    .xferToMem(xferToMem), .xferLen(xferLen), .xferRespValid(xferRespValid),
    .xferAccepted(xferAccepted), .xferGrantLen(xferGrantLen),
    .cmdDone(cmdDone), .dmaEnable(dmaEnable), .abortReq(abortReq), .irq(irq)
  );

  task automatic check(input string tag, input logic [32:0] act, input logic [32:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver tasks: called at a falling edge, hold one cycle
  task automatic wrReg(input int a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = 4'(a); regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input int a, input logic [31:0] exp, input string tag);
    regRdEn = 1'b1; regAddr = 4'(a);
    rdExpQ.push_back(exp); rdTagQ.push_back(tag);
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic xfer(input logic toMem, input logic [31:0] len,
                      input logic acc, input logic [31:0] grant, input string tag);
    xferReq = 1'b1; xferToMem = toMem; xferLen = len;
    xfExpQ.push_back({acc, grant}); xfTagQ.push_back(tag);
    @(negedge clk);
    xferReq = 1'b0;
  endtask

  task automatic pulseDone();
    cmdDone = 1'b1;
    @(negedge clk);
    cmdDone = 1'b0;
  endtask

  // monitor: pops expected items as responses appear
  always @(negedge clk) begin
    if (rstN && regRdValid) begin
      if (rdExpQ.size() == 0) begin
        nChecks++; nFails++;
        $display("FAIL R13 unexpected read data actual=%h expected=none", regRdData);
      end else begin
        check(rdTagQ.pop_front(), {1'b0, regRdData}, {1'b0, rdExpQ.pop_front()});
      end
    end
    if (rstN && xferRespValid) begin
      if (xfExpQ.size() == 0) begin
        nChecks++; nFails++;
        $display("FAIL R13 unexpected transfer response actual=%h expected=none", xferGrantLen);
      end else begin
        check(xfTagQ.pop_front(), {xferAccepted, xferGrantLen}, xfExpQ.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL R13 watchdog actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1 dmaEnable", {32'b0, dmaEnable}, 33'd0);
    check("R1 irq", {32'b0, irq}, 33'd0);
    check("R1 abortReq", {32'b0, abortReq}, 33'd0);
    rdReg(0, 32'h0, "R1 command");
    rdReg(3, 32'h0, "R1 working count");
    rdReg(4, 32'hFFFF_FFFF, "R1 working address");
    rdReg(7, 32'hFFFF_FFFD, "R1 working descriptor");
    rdReg(5, 32'h0, "R1 status");

    // R2 start registers and ignored writes
    wrReg(1, 32'h100);
    wrReg(2, 32'h1000);
    wrReg(6, 32'hABC0);
    rdReg(1, 32'h100, "R2 start count");
    rdReg(2, 32'h1000, "R2 start address");
    rdReg(6, 32'hABC0, "R2 start descriptor");
    wrReg(3, 32'h5);
    wrReg(4, 32'h77);
    wrReg(7, 32'h99);
    wrReg(12, 32'h1234);
    rdReg(3, 32'h0, "R2 working count write ignored");
    rdReg(4, 32'hFFFF_FFFF, "R2 working address write ignored");
    rdReg(7, 32'hFFFF_FFFD, "R2 working descriptor write ignored");
    rdReg(12, 32'h0, "R2 unused index");

    // R3 START
    wrReg(0, 32'h03);
    check("R3 dmaEnable after START", {32'b0, dmaEnable}, 33'd1);
    rdReg(3, 32'h100, "R3 working count loaded");
    rdReg(4, 32'h1000, "R3 working address loaded");
    rdReg(7, 32'hABC0, "R3 working descriptor loaded");
    rdReg(0, 32'h03, "R3 command readback");

    // R5 direction mismatch
    xfer(1'b1, 32'h8, 1'b0, 32'h0, "R5 rejected request");
    rdReg(3, 32'h100, "R5 count unchanged");
    rdReg(4, 32'h1000, "R5 address unchanged");

    // R6 accepted and clipped requests
    xfer(1'b0, 32'h40, 1'b1, 32'h40, "R6 grant full length");
    rdReg(3, 32'hC0, "R6 count reduced");
    rdReg(4, 32'h1040, "R6 address advanced");
    xfer(1'b0, 32'h200, 1'b1, 32'hC0, "R6 grant clipped");
    rdReg(3, 32'h0, "R6 count exhausted");
    rdReg(4, 32'h1100, "R6 address after clip");
    xfer(1'b0, 32'h4, 1'b1, 32'h0, "R6 grant zero when empty");

    // R7 completion, R11 irq on done
    wrReg(0, 32'h43);
    check("R11 irq before done", {32'b0, irq}, 33'd0);
    pulseDone();
    check("R11 irq with done enabled", {32'b0, irq}, 33'd1);
    rdReg(5, 32'h08, "R7 done flag");
    rdReg(3, 32'h0, "R7 count zeroed");

    // R8 write-one-to-clear
    wrReg(5, 32'h08);
    rdReg(5, 32'h0, "R8 done cleared by write");
    check("R8 irq after clear", {32'b0, irq}, 33'd0);

    // R10 interrupt merge, R11 enable gating, R4 IDLE
    scsiIntIn = 1'b1;
    rdReg(5, 32'h10, "R10 scsi interrupt in status");
    check("R11 irq gated off", {32'b0, irq}, 33'd0);
    wrReg(0, 32'h20);
    check("R4 IDLE drops dmaEnable", {32'b0, dmaEnable}, 33'd0);
    check("R11 irq from scsi interrupt", {32'b0, irq}, 33'd1);
    scsiIntIn = 1'b0;
    #1;
    check("R11 irq follows scsi interrupt", {32'b0, irq}, 33'd0);

    // R4 BLAST and ABORT
    @(negedge clk);
    wrReg(0, 32'h03);
    wrReg(0, 32'h01);
    check("R4 BLAST keeps dmaEnable", {32'b0, dmaEnable}, 33'd1);
    rdReg(3, 32'h100, "R4 BLAST keeps count");
    check("R4 no abort yet", {32'b0, abortReq}, 33'd0);
    wrReg(0, 32'h02);
    check("R4 abort pulse", {32'b0, abortReq}, 33'd1);
    @(negedge clk);
    check("R4 abort one cycle", {32'b0, abortReq}, 33'd0);

    // R9 read-to-clear policy
    wrReg(8, 32'h1000);
    rdReg(8, 32'h1000, "R9 bus control readback");
    pulseDone();
    wrReg(5, 32'h08);
    rdReg(5, 32'h08, "R9 status write ignored");
    rdReg(5, 32'h00, "R9 cleared by read");

    // R12 coincident events
    wrReg(8, 32'h0);
    cmdDone = 1'b1;
    wrReg(5, 32'h08);
    cmdDone = 1'b0;
    rdReg(5, 32'h08, "R12 done set beats clear");
    wrReg(0, 32'h03);
    cmdDone = 1'b1;
    xfer(1'b0, 32'h10, 1'b1, 32'h10, "R12 grant alongside done");
    cmdDone = 1'b0;
    rdReg(3, 32'h0, "R12 count zero beats decrement");
    rdReg(4, 32'h1010, "R12 address still advances");

    repeat (3) @(negedge clk);
    check("R13 all reads answered", 33'(rdExpQ.size()), 33'd0);
    check("R13 all transfers answered", 33'(xfExpQ.size()), 33'd0);
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule